// File: doc/BRIEF.md
# XOR Space Compactor with Signature Register

This block sits at the response end of a self-test that loads many scan chains in parallel. On every shift cycle it reduces the wide bus of chain output bits to a narrower word. Each output lane is the XOR of chain bits that lie a fixed stride apart. It then folds that word into a multiple-input signature register (MISR). Compaction runs in the same cycles in which the next pattern is shifted into the chains. During capture cycles the register is left alone by holding the enable low.

When the session ends, the accumulated signature is checked in one of two ways:

- A compare strobe checks it against a reference signature supplied as a parameter and registers a pass flag.
- The register is switched into a plain shift register and its contents are sent out serially on a single output, least significant bit first.

Top module: `xor_sig_compactor`

## Requirements
- R1: While `rst_n` is low, the signature register and `pass_flag` are zero, so `sig_out` reads 0.
- R2: Lane i of the compacted word is the XOR of chain bits i and i+16 (with the default 32 chains and 16 lanes). Two equal halves of the chain bus therefore contribute nothing.
- R3: When `compact_en` is high and neither `clear` nor `unload` is high, the register takes the value (S >> 1) XOR (S[0] ? POLY : 0) XOR lanes on the next edge. POLY defaults to 16'hB400, with feedback taps at bits 15, 13, 12 and 10.
- R4: When `compact_en`, `clear` and `unload` are all low, the register keeps its value.
- R5: `clear` has priority over every other control. It zeroes the register and `pass_flag` on the next edge, even if `unload`, `compact_en` or `cmp_strobe` is high in the same cycle.
- R6: When `unload` is high and `clear` is low, the register shifts right by one with a zero entering bit 15. This takes priority over `compact_en`. `sig_out` always shows bit 0, so the signature leaves least significant bit first and 16 unload cycles leave the register at zero.
- R7: A `cmp_strobe` in a cycle without `clear` sets `pass_flag` on the next edge to 1 exactly when the register value in the strobe cycle, before any update in that cycle, equals `REF_SIG`.
- R8: Without `cmp_strobe` or `clear`, `pass_flag` keeps its value while the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_out | input | CHAINS (32) | Scan-chain output bits for the current shift cycle |
| compact_en | input | 1 | Fold the compacted word into the signature |
| clear | input | 1 | Zero the signature and pass flag |
| cmp_strobe | input | 1 | Compare the signature with `REF_SIG` |
| unload | input | 1 | Shift the signature out serially |
| sig_out | output | 1 | Serial signature bit (bit 0 of the register) |
| pass_flag | output | 1 | Registered result of the last compare |

## Verification
Two functions can land in the same cycle: the compare strobe and the final fold of the signature. The bench provokes this by raising `cmp_strobe` together with `compact_en` and fresh chain data on the cycle right after the last table vector. A pass there shows that the flag judged the value held before that fold. A second strobe one cycle later must then see the folded value and fail. The bench also drives clear together with unload, enable and strobe, and expects a zero signature and a low flag.

// File: rtl/xor_sig_compactor.sv
module xor_sig_compactor #(
  parameter int CHAINS = 32,
  parameter int LANES = 16,
  parameter logic [LANES-1:0] POLY = 16'hB400,
  parameter logic [LANES-1:0] REF_SIG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAINS-1:0] chain_out,
  input  logic              compact_en,
  input  logic              clear,
  input  logic              cmp_strobe,
  input  logic              unload,
  output logic              sig_out,
  output logic              pass_flag
);
  localparam int GROUP = CHAINS / LANES;

  logic [LANES-1:0] lanes;
  logic [LANES-1:0] misr;
  logic [LANES-1:0] misr_nx;

  always_comb begin
    lanes = '0;
    for (int g = 0; g < GROUP; g++)
      lanes ^= chain_out[g*LANES +: LANES];
  end

  always_comb begin
    if (clear)           misr_nx = '0;
    else if (unload)     misr_nx = {1'b0, misr[LANES-1:1]};
    else if (compact_en) misr_nx = {1'b0, misr[LANES-1:1]} ^ (misr[0] ? POLY : '0) ^ lanes;
    else                 misr_nx = misr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misr      <= '0;
      pass_flag <= 1'b0;
    end else begin
      misr <= misr_nx;
      if (clear)           pass_flag <= 1'b0;
      else if (cmp_strobe) pass_flag <= (misr == REF_SIG);
    end
  end

  assign sig_out = misr[0];
endmodule

// File: rtl/xor_sig_compactor_chk.sv
module xor_sig_compactor_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] REF = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         compact_en,
  input logic         clear,
  input logic         cmp_strobe,
  input logic         unload,
  input logic [W-1:0] misr,
  input logic         sig_out,
  input logic         pass_flag
);
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (misr == '0) && !pass_flag);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !unload && !compact_en) |=> $stable(misr));

  // R6
  unload_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && unload) |=> (misr == ($past(misr) >> 1)) && (sig_out == $past(misr[1])));

  // R7
  compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cmp_strobe) |=> (pass_flag == ($past(misr) == REF)));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cmp_strobe) |=> $stable(pass_flag));

  // R1
  always_comb if (!rst_n) reset_state_chk: assert (misr == '0 && !pass_flag);
endmodule

bind xor_sig_compactor xor_sig_compactor_chk #(.W(LANES), .REF(REF_SIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .compact_en(compact_en), .clear(clear),
  .cmp_strobe(cmp_strobe), .unload(unload), .misr(misr),
  .sig_out(sig_out), .pass_flag(pass_flag)
);

// File: tb/test_xor_sig_compactor.sv
`timescale 1ns/1ps
module test_xor_sig_compactor;
  localparam logic [15:0] POLY = 16'hB400;
  localparam int NV = 12;
  // {compact_en, chain_out}
  localparam logic [32:0] VEC [NV] = '{
    33'h1_DEAD_BEEF, 33'h1_1234_5678, 33'h0_FFFF_0000, 33'h1_0F0F_F0F0,
    33'h1_A5A5_5A5A, 33'h1_0000_0001, 33'h0_8000_0000, 33'h1_CAFE_F00D,
    33'h1_1357_9BDF, 33'h1_FFFF_FFFF, 33'h1_8001_0001, 33'h1_7654_3210
  };

  function automatic logic [15:0] fold(logic [15:0] s, logic [31:0] c);
    logic [15:0] ln;
    ln = c[15:0] ^ c[31:16];
    return {1'b0, s[15:1]} ^ (s[0] ? POLY : 16'h0) ^ ln;
  endfunction

  function automatic logic [15:0] golden();
    logic [15:0] s;
    s = '0;
    for (int k = 0; k < NV; k++) if (VEC[k][32]) s = fold(s, VEC[k][31:0]);
    return s;
  endfunction

  localparam logic [15:0] GOLD = golden();

  logic clk = 0, rst_n = 0;
  logic [31:0] chain_out = '0;
  logic compact_en = 0, clear = 0, cmp_strobe = 0, unload = 0;
  logic sig_out, pass_flag;
  int total = 0, bad = 0;
  logic [15:0] exp_s;

  always #4 clk = ~clk;

  xor_sig_compactor #(.POLY(POLY), .REF_SIG(GOLD)) i_xor_sig_compactor (
    .clk(clk), .rst_n(rst_n), .chain_out(chain_out), .compact_en(compact_en),
    .clear(clear), .cmp_strobe(cmp_strobe), .unload(unload),
    .sig_out(sig_out), .pass_flag(pass_flag));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic cl, logic st, logic un, logic [31:0] c);
    compact_en = en; clear = cl; cmp_strobe = st; unload = un; chain_out = c;
    @(posedge clk); @(negedge clk);
    compact_en = 0; clear = 0; cmp_strobe = 0; unload = 0;
  endtask

  task automatic unload_chk(string tag, logic [15:0] exp);
    logic [15:0] got;
    for (int k = 0; k < 16; k++) begin
      got[k] = sig_out;
      step(1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_0001);
    end
    chk(tag, got, exp);
    chk({tag, " empty"}, {15'b0, sig_out}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sig_out", {15'b0, sig_out}, 16'h0);
    chk("R1 reset pass", {15'b0, pass_flag}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    step(0, 1, 0, 0, '0);
    exp_s = '0;
    // R3 R4: table walk
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][32], 0, 0, 0, VEC[k][31:0]);
      if (VEC[k][32]) exp_s = fold(exp_s, VEC[k][31:0]);
      chk($sformatf("R3/R4 vec%0d sig_out", k), {15'b0, sig_out}, {15'b0, exp_s[0]});
    end
    chk("R3 table signature", exp_s, GOLD);
    // R7: strobe in the same cycle as a fold judges pre-fold value
    step(1, 0, 1, 0, 32'h0BAD_F00D);
    chk("R7 strobe with fold", {15'b0, pass_flag}, 16'h1);
    exp_s = fold(exp_s, 32'h0BAD_F00D);
    step(0, 0, 1, 0, '0);
    chk("R7 strobe after fold", {15'b0, pass_flag}, {15'b0, exp_s == GOLD});
    // R6: unload LSB first
    unload_chk("R6 unload bits", exp_s);
    // R8: flag holds without strobe
    step(0, 1, 0, 0, '0);
    for (int k = 0; k < NV; k++) if (VEC[k][32]) step(1, 0, 0, 0, VEC[k][31:0]);
    step(0, 0, 1, 0, '0);
    chk("R7 pass again", {15'b0, pass_flag}, 16'h1);
    step(1, 0, 0, 0, 32'h0000_0100);
    step(1, 0, 0, 0, 32'h0042_0000);
    chk("R8 flag held", {15'b0, pass_flag}, 16'h1);
    // R5: clear beats unload, enable and strobe
    step(1, 1, 1, 1, 32'hFFFF_1234);
    chk("R5 clear pass", {15'b0, pass_flag}, 16'h0);
    unload_chk("R5 clear signature", 16'h0);
    // R2: equal halves cancel
    step(1, 0, 0, 0, 32'h5A3C_5A3C);
    unload_chk("R2 cancel", 16'h0);
    // R2: upper chain bit lands on its lane
    step(1, 0, 0, 0, 32'h0008_0000);
    unload_chk("R2 upper lane3", 16'h0008);
    step(1, 0, 0, 0, 32'h0000_8000);
    unload_chk("R2 lower lane15", 16'h8000);
    // R3: feedback path from bit 0
    step(1, 0, 0, 0, 32'h0000_0001);
    step(1, 0, 0, 0, 32'h0000_0000);
    unload_chk("R3 feedback", POLY);
    // R4: hold with idle controls
    step(1, 0, 0, 0, 32'h0000_00F0);
    step(0, 0, 0, 0, 32'hFFFF_FFFF);
    step(0, 0, 1, 0, 32'h1234_0000);
    chk("R7 mismatch", {15'b0, pass_flag}, {15'b0, 16'h00F0 == GOLD});
    unload_chk("R4 hold", 16'h00F0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule